// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits beside the ALU of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the two source register numbers of the instruction in execute. It compares them with the destination register and write enable of the two older instructions still in flight: the one in the memory stage and the one in the writeback stage. For each operand it produces a 2-bit select that drives a three-way operand multiplexer. The multiplexer picks one of three values: the register value captured in decode, the result held at the memory-stage boundary, or the result held at the writeback-stage boundary.

Producers three or more instructions older need no bypass. The register file commits a write in the first half of a cycle and serves reads in the second half, so decode already sees that value. Results are bypassed as soon as they exist, which lets back-to-back dependent ALU instructions run with no bubble. The block is purely combinational. Load-use stall detection, the ALU and the register file are outside it.

Top module: `fwd_unit`

## Requirements
- R1: When neither older instruction writes a register equal to a given source, that operand's select is 2'b00, which passes the decode-stage register value.
- R2: When the memory-stage instruction has its write enable high and its nonzero destination equals a source, that operand's select is 2'b10, which passes the memory-stage result.
- R3: When only the writeback-stage instruction has its write enable high and its nonzero destination equals a source, that operand's select is 2'b01, which passes the writeback-stage result.
- R4: When both older instructions qualify for the same source, the memory-stage result wins and the select is 2'b10.
- R5: A producer whose write enable is low is never a bypass source, even if its destination equals the source. If the other producer qualifies, the select falls to that producer.
- R6: Register number 0 is never bypassed. A source of 0 always yields select 2'b00, whatever the destinations and enables are.
- R7: The two operands are resolved independently. In the same cycle, operand A and operand B may take different selects.
- R8: The select value 2'b11 never appears on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src_a | input | REG_AW | First source register number of the execute-stage instruction |
| ex_src_b | input | REG_AW | Second source register number of the execute-stage instruction |
| mem_wr_en | input | 1 | Register write enable of the memory-stage instruction |
| mem_dst | input | REG_AW | Destination register of the memory-stage instruction |
| wb_wr_en | input | 1 | Register write enable of the writeback-stage instruction |
| wb_dst | input | REG_AW | Destination register of the writeback-stage instruction |
| sel_a | output | 2 | Operand A source select (00 decode, 10 memory stage, 01 writeback stage) |
| sel_b | output | 2 | Operand B source select, same encoding |

## Verification
The block holds no state, so any fault shows up on sel_a or sel_b in the same cycle as the input pattern that exposes it. A broken comparator or a dropped enable produces a select of 00 where a bypass is due, or a bypass where none is due. A reversed priority shows up only when both producers name the same source. A crossed lane shows up only when the two operands need different selects. The stimulus therefore includes directed cases that isolate each of these situations, followed by a random sweep over a narrow register range so that matches happen often.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // Operand source select encoding seen by the ALU operand muxes
    typedef enum logic [1:0] {
        FWD_NONE = 2'b00,   // value read in decode
        FWD_WB   = 2'b01,   // writeback-stage result
        FWD_MEM  = 2'b10    // memory-stage result (most recent)
    } fwd_sel_e;

    localparam int NUM_PRODUCERS = 2;

    // Priority resolution: nearer producer wins
    function automatic fwd_sel_e resolve(input logic near_hit, input logic far_hit);
        if (near_hit)
            return FWD_MEM;
        else if (far_hit)
            return FWD_WB;
        else
            return FWD_NONE;
    endfunction

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] dst,
    input  logic              wr_en,
    output logic              hit
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    always_comb begin
        hit = wr_en && (dst != ZERO_REG) && (dst == src);
    end
endmodule

// File: rtl/fwd_operand.sv
module fwd_operand
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              mem_wr_en,
    input  logic [REG_AW-1:0] wb_dst,
    input  logic              wb_wr_en,
    output fwd_sel_e          sel
);
    logic [NUM_PRODUCERS-1:0]  hits;
    logic [REG_AW-1:0]         p_dst [NUM_PRODUCERS];
    logic [NUM_PRODUCERS-1:0]  p_en;

    // index 0 = memory stage (nearer), index 1 = writeback stage
    always_comb begin
        p_dst[0] = mem_dst;
        p_dst[1] = wb_dst;
        p_en[0]  = mem_wr_en;
        p_en[1]  = wb_wr_en;
    end

    for (genvar p = 0; p < NUM_PRODUCERS; p++) begin : g_prod
        fwd_match #(.REG_AW(REG_AW)) u_match (
            .src   (src),
            .dst   (p_dst[p]),
            .wr_en (p_en[p]),
            .hit   (hits[p])
        );
    end

    always_comb begin
        sel = resolve(hits[0], hits[1]);
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] ex_src_a,
    input  logic [REG_AW-1:0] ex_src_b,
    input  logic              mem_wr_en,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              wb_wr_en,
    input  logic [REG_AW-1:0] wb_dst,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b
);
    localparam int NUM_SRC = 2;

    logic [REG_AW-1:0] srcs [NUM_SRC];
    fwd_sel_e          sels [NUM_SRC];

    always_comb begin
        srcs[0] = ex_src_a;
        srcs[1] = ex_src_b;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        fwd_operand #(.REG_AW(REG_AW)) u_op (
            .src       (srcs[s]),
            .mem_dst   (mem_dst),
            .mem_wr_en (mem_wr_en),
            .wb_dst    (wb_dst),
            .wb_wr_en  (wb_wr_en),
            .sel       (sels[s])
        );
    end

    always_comb begin
        sel_a = sels[0];
        sel_b = sels[1];
    end
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int REG_AW = 5
) (
    input logic [REG_AW-1:0] ex_src_a,
    input logic [REG_AW-1:0] ex_src_b,
    input logic              mem_wr_en,
    input logic [REG_AW-1:0] mem_dst,
    input logic              wb_wr_en,
    input logic [REG_AW-1:0] wb_dst,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b
);
    localparam logic [REG_AW-1:0] R0 = '0;

    always_comb begin
        assert_legal_code_R8: assert (sel_a != 2'b11 && sel_b != 2'b11);

        if (ex_src_a == R0) assert_zero_a_R6: assert (sel_a == 2'b00);
        if (ex_src_b == R0) assert_zero_b_R6: assert (sel_b == 2'b00);

        if (sel_a == 2'b10) assert_mem_a_R2: assert (mem_wr_en && mem_dst == ex_src_a);
        if (sel_b == 2'b10) assert_mem_b_R2: assert (mem_wr_en && mem_dst == ex_src_b);

        if (sel_a == 2'b01) assert_wb_a_R3: assert (wb_wr_en && wb_dst == ex_src_a);
        if (sel_b == 2'b01) assert_wb_b_R3: assert (wb_wr_en && wb_dst == ex_src_b);

        if (mem_wr_en && mem_dst == ex_src_a && ex_src_a != R0)
            assert_newest_a_R4: assert (sel_a == 2'b10);
        if (mem_wr_en && mem_dst == ex_src_b && ex_src_b != R0)
            assert_newest_b_R4: assert (sel_b == 2'b10);
    end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_AW(REG_AW)) u_chk (
    .ex_src_a  (ex_src_a),
    .ex_src_b  (ex_src_b),
    .mem_wr_en (mem_wr_en),
    .mem_dst   (mem_dst),
    .wb_wr_en  (wb_wr_en),
    .wb_dst    (wb_dst),
    .sel_a     (sel_a),
    .sel_b     (sel_b)
);

// File: tb/fwd_unit_test.sv
module fwd_unit_test;
    localparam int AW = 5;
    localparam int WATCHDOG = 100000;

    typedef struct {
        logic [1:0] exp;
        string      tag;
        int         lane;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] ex_src_a = '0, ex_src_b = '0, mem_dst = '0, wb_dst = '0;
    logic          mem_wr_en = 1'b0, wb_wr_en = 1'b0;
    logic [1:0]    sel_a, sel_b;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    fwd_unit #(.REG_AW(AW)) uut (
        .ex_src_a (ex_src_a),
        .ex_src_b (ex_src_b),
        .mem_wr_en(mem_wr_en),
        .mem_dst  (mem_dst),
        .wb_wr_en (wb_wr_en),
        .wb_dst   (wb_dst),
        .sel_a    (sel_a),
        .sel_b    (sel_b)
    );

    // Reference model straight from the requirements
    function automatic logic [1:0] model(input logic [AW-1:0] s);
        if (s == '0) return 2'b00;                       // R6
        if (mem_wr_en && mem_dst == s) return 2'b10;    // R2 / R4
        if (wb_wr_en && wb_dst == s) return 2'b01;      // R3
        return 2'b00;                                    // R1 / R5
    endfunction

    function automatic string classify(input logic [AW-1:0] s);
        logic mh, wh;
        mh = mem_wr_en && mem_dst == s;
        wh = wb_wr_en && wb_dst == s;
        if (s == '0) return "R6";
        if (mh && wh) return "R4";
        if (mh) return "R2";
        if (wh) return "R3";
        if (mem_dst == s || wb_dst == s) return "R5";
        return "R1";
    endfunction

    task automatic apply(input logic [AW-1:0] sa, input logic [AW-1:0] sb,
                         input logic me, input logic [AW-1:0] md,
                         input logic we, input logic [AW-1:0] wd,
                         input string tag);
        item_t ia, ib;
        @(posedge clk);
        ex_src_a = sa; ex_src_b = sb;
        mem_wr_en = me; mem_dst = md;
        wb_wr_en = we; wb_dst = wd;
        ia.exp = model(sa); ia.lane = 0;
        ib.exp = model(sb); ib.lane = 1;
        ia.tag = (tag == "") ? classify(sa) : tag;
        ib.tag = (tag == "") ? classify(sb) : tag;
        q.push_back(ia);
        q.push_back(ib);
    endtask

    // Monitor: compare away from the driving edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [1:0] act;
            it = q.pop_front();
            act = (it.lane == 0) ? sel_a : sel_b;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s lane %0d: actual %b expected %b", it.tag, it.lane, act, it.exp);
            end
            checks++;
            if (act === 2'b11) begin   // R8
                errors++;
                $display("FAIL R8 lane %0d: actual %b expected not 11", it.lane, act);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // idle state after reset: all zero inputs -> decode value (R6)
        apply(0, 0, 0, 0, 0, 0, "R6");
        // R1: no matching producer
        apply(3, 4, 1, 7, 1, 9, "R1");
        // R2: memory-stage hit on A, nothing on B
        apply(5, 6, 1, 5, 0, 0, "");
        // R3: writeback-stage hit on B
        apply(8, 12, 0, 0, 1, 12, "");
        // R4: both producers write the same register
        apply(10, 10, 1, 10, 1, 10, "R4");
        // R5: enable low on memory stage, writeback match takes over
        apply(11, 11, 0, 11, 1, 11, "R5");
        // R5: both enables low, destinations match
        apply(13, 13, 0, 13, 0, 13, "R5");
        // R6: register 0 with all enables high
        apply(0, 0, 1, 0, 1, 0, "R6");
        // R7: A from memory stage, B from writeback stage in the same cycle
        apply(2, 9, 1, 2, 1, 9, "R7");
        // R7: reversed lanes
        apply(9, 2, 1, 2, 1, 9, "R7");
        // highest register number
        apply(31, 31, 1, 31, 0, 31, "R2");
        // random sweep, small register range for frequent matches
        for (int i = 0; i < 400; i++) begin
            apply(AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
                  1'($urandom), AW'($urandom_range(0, 3)),
                  1'($urandom), AW'($urandom_range(0, 3)), "");
        end
        @(posedge clk);
        @(negedge clk);
        #1;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule